// File: doc/BRIEF.md
# Bridge VGA/ISA Transaction Router

This block is the routing core of a virtual PCI-to-PCI bridge that sits between a host processor and a secondary graphics bus. For every CPU-initiated memory or I/O transaction it decides whether the access is forwarded to the secondary bus or left on the primary PCI bus. The decision combines three things: the I/O and memory base/limit windows, which arrive as input values; a fixed set of legacy VGA address ranges; and an ISA compatibility mode that keeps part of every 1 KB I/O block on the primary bus.

An 8-bit bridge control register is reached over a simple register port. A write is applied on the next clock edge, and reads are combinational. The register holds three live settings: VGA forwarding, ISA carving and the parity error response. All of its other bits read as fixed values. The same register also decides whether parity errors on the secondary bus are passed on to a system error output. That output is further gated by two system-error enable inputs.

Top module: `vga_isa_router`

## Requirements
- R1: After reset, `reg_rdata` reads 80h.
- R2: Bit 7 always reads 1. Bits 6, 5, 4 and 1 always read 0, and writes to these bits are ignored. Bits 3 (VGA forwarding), 2 (ISA carving) and 0 (parity error response) take the written value on the clock edge where `reg_wr` is high, and read back from the following cycle.
- R3: With bit 3 set, a memory transaction (`txn_is_io`=0) whose address lies in 0A0000h..0BFFFFh is routed to the secondary bus.
- R4: With bit 3 set, an I/O transaction (`txn_is_io`=1) whose address bits [9:0] lie in 3B0h..3BBh or 3C0h..3DFh is routed to the secondary bus. Address bits [15:10] are not examined.
- R5: With bit 3 set, the routing of an access in a VGA range does not depend on the windows or on bit 2.
- R6: With bit 3 clear, an access in a VGA range goes to the secondary bus only if the matching base/limit window contains it.
- R7: With bit 2 set, an I/O address inside the I/O window goes to the primary bus when its bits [9:8] are nonzero, unless R4 applies.
- R8: With bit 2 clear, every I/O address inside the I/O window goes to the secondary bus.
- R9: `serr_out` is high one cycle after `sec_perr` only when bit 0, `serr_en_a` and `serr_en_b` are all 1. Otherwise it is 0.
- R10: A window contains an address when base <= address <= limit, with both bounds inclusive, compared over 16 bits for I/O and 32 bits for memory. A window with base > limit contains nothing.
- R11: The decision is registered. `route_valid` equals `txn_valid` delayed by one cycle. `route_sec` (1 = secondary, 0 = primary) carries the decision in that cycle and is 0 when no transaction was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_is_io | input | 1 | 1 = I/O transaction, 0 = memory transaction |
| txn_addr | input | 32 | Transaction address (I/O uses bits [15:0]) |
| io_base | input | 16 | I/O window lower bound |
| io_limit | input | 16 | I/O window upper bound |
| mem_base | input | 32 | Memory window lower bound |
| mem_limit | input | 32 | Memory window upper bound |
| sec_perr | input | 1 | Address or data parity error seen on the secondary bus |
| serr_en_a | input | 1 | First system-error enable |
| serr_en_b | input | 1 | Second system-error enable |
| route_valid | output | 1 | Decision valid (one cycle after txn_valid) |
| route_sec | output | 1 | 1 = forward to secondary bus, 0 = primary |
| serr_out | output | 1 | System error report |

## Verification
A wrong control bit appears on `reg_rdata` in the cycle after the write. It also changes the decision of the very next transaction that falls in a VGA range or inside the I/O window. An off-by-one in a window compare or in a VGA range edge shows up as a single wrong `route_sec` at that boundary address. The bench therefore sweeps every I/O address in several 1 KB blocks and walks memory across both window edges, and a fault is caught one cycle after the offending transaction. A gating fault on the error path appears on `serr_out` one cycle after the input combination that exposes it.

// File: rtl/bridge_route_pkg.sv
package bridge_route_pkg;

    localparam int ADDR_W = 32;
    localparam int IO_W   = 16;

    localparam logic [ADDR_W-1:0] VGA_MEM_LO = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] VGA_MEM_HI = 32'h000B_FFFF;

    typedef enum logic { ROUTE_PRI = 1'b0, ROUTE_SEC = 1'b1 } route_e;

    typedef struct packed {
        logic vga_fwd;
        logic isa_carve;
        logic perr_resp;
    } ctrl_t;

    function automatic logic vga_mem_hit(input logic [ADDR_W-1:0] a);
        return (a >= VGA_MEM_LO) && (a <= VGA_MEM_HI);
    endfunction

    function automatic logic vga_io_hit(input logic [9:0] a);
        return ((a >= 10'h3B0) && (a <= 10'h3BB)) ||
               ((a >= 10'h3C0) && (a <= 10'h3DF));
    endfunction

    function automatic logic [7:0] pack_ctrl(input ctrl_t c);
        return {4'b1000, c.vga_fwd, c.isa_carve, 1'b0, c.perr_resp};
    endfunction

endpackage

// File: rtl/bctrl_reg.sv
module bctrl_reg
    import bridge_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output ctrl_t      ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q.vga_fwd   <= wdata[3];
            ctrl_q.isa_carve <= wdata[2];
            ctrl_q.perr_resp <= wdata[0];
        end
    end

    assign ctrl  = ctrl_q;
    assign rdata = pack_ctrl(ctrl_q);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr |=> (rdata[3] == $past(wdata[3])) && (rdata[2] == $past(wdata[2]))
               && (rdata[0] == $past(wdata[0])));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(rdata));

endmodule

// File: rtl/window_cmp.sv
module window_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    output logic         hit
);
    assign hit = (addr >= base) && (addr <= limit);

    always_comb begin
        if (base > limit) assert_empty_R10: assert (!hit);
    end
endmodule

// File: rtl/vga_isa_router.sv
module vga_isa_router
    import bridge_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              txn_valid,
    input  logic              txn_is_io,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [IO_W-1:0]   io_base,
    input  logic [IO_W-1:0]   io_limit,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] mem_limit,
    input  logic              sec_perr,
    input  logic              serr_en_a,
    input  logic              serr_en_b,
    output logic              route_valid,
    output logic              route_sec,
    output logic              serr_out
);
    ctrl_t  ctrl;
    logic   io_win_hit, mem_win_hit;
    logic   vga_claim, win_claim, carve;
    route_e route_d;
    logic   valid_q, serr_q;
    route_e route_q;

    bctrl_reg ctrl_i (
        .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
        .rdata(reg_rdata), .ctrl(ctrl)
    );

    window_cmp #(.W(IO_W)) io_win_i (
        .addr(txn_addr[IO_W-1:0]), .base(io_base), .limit(io_limit), .hit(io_win_hit)
    );

    window_cmp #(.W(ADDR_W)) mem_win_i (
        .addr(txn_addr), .base(mem_base), .limit(mem_limit), .hit(mem_win_hit)
    );

    always_comb begin
        carve = ctrl.isa_carve && (txn_addr[9:8] != 2'b00);
        if (txn_is_io) begin
            vga_claim = ctrl.vga_fwd && vga_io_hit(txn_addr[9:0]);
            win_claim = io_win_hit && !carve;
        end else begin
            vga_claim = ctrl.vga_fwd && vga_mem_hit(txn_addr);
            win_claim = mem_win_hit;
        end
        route_d = (vga_claim || win_claim) ? ROUTE_SEC : ROUTE_PRI;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            route_q <= ROUTE_PRI;
            serr_q  <= 1'b0;
        end else begin
            valid_q <= txn_valid;
            route_q <= txn_valid ? route_d : ROUTE_PRI;
            serr_q  <= sec_perr && ctrl.perr_resp && serr_en_a && serr_en_b;
        end
    end

    assign route_valid = valid_q;
    assign route_sec   = (route_q == ROUTE_SEC);
    assign serr_out    = serr_q;

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !txn_valid |=> !route_valid && !route_sec);

    assert_vga_mem_R3: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_is_io && ctrl.vga_fwd && txn_addr >= VGA_MEM_LO
         && txn_addr <= VGA_MEM_HI) |=> route_sec);

    assert_isa_carve_R7: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_is_io && !ctrl.vga_fwd && ctrl.isa_carve
         && txn_addr[9:8] != 2'b00) |=> !route_sec);

    assert_serr_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.perr_resp || !serr_en_a || !serr_en_b || !sec_perr) |=> !serr_out);

endmodule

// File: tb/vga_isa_router_tb_top.sv
module vga_isa_router_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        txn_valid, txn_is_io;
    logic [31:0] txn_addr;
    logic [15:0] io_base, io_limit;
    logic [31:0] mem_base, mem_limit;
    logic        sec_perr, serr_en_a, serr_en_b;
    logic        route_valid, route_sec, serr_out;

    int checks = 0;
    int errors = 0;
    bit vga, isa;

    always #5 clk = ~clk;

    vga_isa_router dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .txn_valid(txn_valid), .txn_is_io(txn_is_io),
        .txn_addr(txn_addr), .io_base(io_base), .io_limit(io_limit),
        .mem_base(mem_base), .mem_limit(mem_limit), .sec_perr(sec_perr),
        .serr_en_a(serr_en_a), .serr_en_b(serr_en_b), .route_valid(route_valid),
        .route_sec(route_sec), .serr_out(serr_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_route(input bit io, input logic [31:0] a);
        int lo;
        bit vhit, whit;
        lo = int'(a[9:0]);
        if (io) begin
            vhit = vga && ((lo >= 'h3B0 && lo <= 'h3BB) || (lo >= 'h3C0 && lo <= 'h3DF));
            whit = (a[15:0] >= io_base) && (a[15:0] <= io_limit) && !(isa && (lo >= 256));
        end else begin
            vhit = vga && (a >= 32'hA0000) && (a <= 32'hBFFFF);
            whit = (a >= mem_base) && (a <= mem_limit);
        end
        return vhit || whit;
    endfunction

    task automatic write_reg(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        vga = d[3]; isa = d[2];
    endtask

    task automatic txn(input bit io, input logic [31:0] a, input string req);
        txn_valid = 1'b1; txn_is_io = io; txn_addr = a;
        @(negedge clk);
        txn_valid = 1'b0;
        check({req, " valid"}, {31'd0, route_valid}, 32'd1);
        check(req, {31'd0, route_sec}, {31'd0, exp_route(io, a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_wdata = 0; txn_valid = 0; txn_is_io = 0;
        txn_addr = 0; io_base = 16'h0100; io_limit = 16'h0AFF;
        mem_base = 32'hB0000; mem_limit = 32'hC7FFF;
        sec_perr = 0; serr_en_a = 0; serr_en_b = 0; vga = 0; isa = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset rdata", {24'd0, reg_rdata}, 32'h80);
        @(negedge clk);
        check("R11 idle valid", {31'd0, route_valid}, 32'd0);
        check("R11 idle sec", {31'd0, route_sec}, 32'd0);

        write_reg(8'hFF);
        check("R2 write FF", {24'd0, reg_rdata}, 32'h8D);
        write_reg(8'h00);
        check("R2 write 00", {24'd0, reg_rdata}, 32'h80);
        write_reg(8'h72);
        check("R2 write 72", {24'd0, reg_rdata}, 32'h80);
        write_reg(8'h09);
        check("R2 write 09", {24'd0, reg_rdata}, 32'h89);

        for (int cfg = 0; cfg < 4; cfg++) begin
            write_reg({4'd0, cfg[1], cfg[0], 2'd0});
            io_base = 16'h0100; io_limit = 16'h0AFF;
            for (int a = 0; a < 'h1000; a++) txn(1'b1, a, "R4 R5 R6 R7 R8 io sweep");
            for (int a = 'hFC00; a < 'h10000; a++) txn(1'b1, a, "R4 io alias");
            io_base = 16'h0800; io_limit = 16'h0100;
            for (int a = 0; a < 'h0C00; a += 3) txn(1'b1, a, "R10 empty io window");
            mem_base = 32'hB0000; mem_limit = 32'hC7FFF;
            for (int a = 'h9F000; a < 'hD0000; a += 'h80) txn(1'b0, a, "R3 R6 mem sweep");
            txn(1'b0, 32'h9FFFF, "R3 edge lo-1");
            txn(1'b0, 32'hA0000, "R3 edge lo");
            txn(1'b0, 32'hBFFFF, "R3 edge hi");
            txn(1'b0, 32'hC7FFF, "R10 limit inclusive");
            txn(1'b0, 32'hC8000, "R10 limit+1");
            txn(1'b0, 32'hAFFFF, "R10 base-1");
            mem_base = 32'hC0000; mem_limit = 32'h10000;
            for (int a = 'h9F000; a < 'hD0000; a += 'h400) txn(1'b0, a, "R10 empty mem window");
            mem_base = 32'hB0000; mem_limit = 32'hC7FFF;
        end

        for (int k = 0; k < 16; k++) begin
            write_reg({7'd0, k[3]});
            sec_perr = k[0]; serr_en_a = k[1]; serr_en_b = k[2];
            @(negedge clk);
            check("R9 serr gate", {31'd0, serr_out}, {31'd0, k[3] & k[0] & k[1] & k[2]});
            sec_perr = 0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule